// File: doc/BRIEF.md
# Dual-port mailbox interrupt controller

This block sits beside a dual-port memory of 2^11 bytes and turns its two highest addresses into one-way message slots. The slot at 0x7FE carries messages to the left port. The slot at 0x7FF carries messages to the right port. When one side writes into the slot that belongs to the other side, the block raises that other side's interrupt line. The receiving side drops its line by reading its own slot. The message byte is stored in the memory array as ordinary data, so this block never touches it. It only watches the control and address signals of both ports.

Each port presents an active-low enable, a read/write select (0 means write), an active-low output enable and an address. All of these are sampled on the rising clock edge. A mode input turns the mailbox function on or off. When it is off, the two slots act as plain storage and both interrupt lines stay idle.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: After reset, both interrupt outputs `irq_l_n` and `irq_r_n` are high, which is the deasserted state (the outputs are active-low).
- R2: When mode is on and the right port has `r_ce_n`=0, `r_we_n`=0 and `r_addr`=0x7FE at a clock edge, `irq_l_n` goes low after that edge.
- R3: When mode is on and the left port has `l_ce_n`=0, `l_we_n`=0 and `l_addr`=0x7FF at a clock edge, `irq_r_n` goes low after that edge.
- R4: When mode is on and the left port has `l_ce_n`=0, `l_oe_n`=0 and `l_addr`=0x7FE at a clock edge, `irq_l_n` returns high after that edge. The value of `l_we_n` does not matter for this clear.
- R5: When mode is on and the right port has `r_ce_n`=0, `r_oe_n`=0 and `r_addr`=0x7FF at a clock edge, `irq_r_n` returns high after that edge. The value of `r_we_n` does not matter for this clear.
- R6: If a set and a clear of the same flag are both present at one edge, the flag is asserted (low) after that edge.
- R7: A port that writes its own slot with its output enable high leaves both interrupt outputs unchanged. This covers the left port writing 0x7FE and the right port writing 0x7FF.
- R8: A flag holds its value through any cycle that has no qualifying set or clear. Such cycles include accesses to other addresses, reads of the peer's slot, and accesses made with the enable high.
- R9: While mode is off, qualifying writes set no flag. Both outputs go high after the first edge at which mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mbox_on | input | 1 | 1 enables the mailbox interrupt function |
| l_ce_n | input | 1 | Left port enable, active low |
| l_we_n | input | 1 | Left port read/write select, 0 = write |
| l_oe_n | input | 1 | Left port output enable, active low |
| l_addr | input | 11 | Left port address |
| r_ce_n | input | 1 | Right port enable, active low |
| r_we_n | input | 1 | Right port read/write select, 0 = write |
| r_oe_n | input | 1 | Right port output enable, active low |
| r_addr | input | 11 | Right port address |
| irq_l_n | output | 1 | Interrupt to the left port, active low |
| irq_r_n | output | 1 | Interrupt to the right port, active low |

## Verification
The hardest case to reach is a set and a clear of the same flag landing on the same edge. The bench first raises the flag with a lone cross-port write. In a later cycle it drives the sender's write and the receiver's slot read together, and it confirms that the line stays low. It then repeats the collision with the flag initially clear. A clear that carries write-select low is also tested, to show that the read/write value plays no part in the clear.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    parameter int ADDR_W = 11;

    typedef struct packed {
        logic irq_l;
        logic irq_r;
    } flag_s;
endpackage

// File: rtl/mbox_port_dec.sv
module mbox_port_dec #(
    parameter int                ADDR_W   = 11,
    parameter logic [ADDR_W-1:0] OWN_BOX  = '1,
    parameter logic [ADDR_W-1:0] PEER_BOX = '1
) (
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_peer,
    output logic              rd_own
);
    logic sel;

    always_comb begin
        sel     = ~ce_n;
        wr_peer = sel & ~we_n & (addr == PEER_BOX);
        rd_own  = sel & ~oe_n & (addr == OWN_BOX);
    end
endmodule

// File: rtl/mbox_flags.sv
module mbox_flags
    import mbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode,
    input  logic set_l,
    input  logic clr_l,
    input  logic set_r,
    input  logic clr_r,
    output logic irq_l_n,
    output logic irq_r_n
);
    flag_s flg_d, flg_q;

    always_comb begin
        flg_d = flg_q;
        if (!mode) begin
            flg_d = '0;
        end else begin
            if (clr_l) flg_d.irq_l = 1'b0;
            if (set_l) flg_d.irq_l = 1'b1;
            if (clr_r) flg_d.irq_r = 1'b0;
            if (set_r) flg_d.irq_r = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign irq_l_n = ~flg_q.irq_l;
    assign irq_r_n = ~flg_q.irq_r;

    p_set_l_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && set_l) |=> !irq_l_n);
    p_set_r_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && set_r) |=> !irq_r_n);
    p_clear_l_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && clr_l && !set_l) |=> irq_l_n);
    p_clear_r_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && clr_r && !set_r) |=> irq_r_n);
    p_hold_l_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && !set_l && !clr_l) |=> $stable(irq_l_n));
    p_hold_r_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && !set_r && !clr_r) |=> $stable(irq_r_n));
    p_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mode |=> (irq_l_n && irq_r_n));
endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl
    import mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mbox_on,
    input  logic              l_ce_n,
    input  logic              l_we_n,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_ce_n,
    input  logic              r_we_n,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              irq_l_n,
    output logic              irq_r_n
);
    localparam int                NPORT = 2;
    localparam logic [ADDR_W-1:0] BOX_R = '1;
    localparam logic [ADDR_W-1:0] BOX_L = BOX_R - 1'b1;

    logic [NPORT-1:0] ce_a, we_a, oe_a, wr_peer, rd_own;
    logic [ADDR_W-1:0] addr_a [NPORT];

    assign ce_a      = {r_ce_n, l_ce_n};
    assign we_a      = {r_we_n, l_we_n};
    assign oe_a      = {r_oe_n, l_oe_n};
    assign addr_a[0] = l_addr;
    assign addr_a[1] = r_addr;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        mbox_port_dec #(
            .ADDR_W  (ADDR_W),
            .OWN_BOX ((p == 0) ? BOX_L : BOX_R),
            .PEER_BOX((p == 0) ? BOX_R : BOX_L)
        ) u_dec (
            .ce_n   (ce_a[p]),
            .we_n   (we_a[p]),
            .oe_n   (oe_a[p]),
            .addr   (addr_a[p]),
            .wr_peer(wr_peer[p]),
            .rd_own (rd_own[p])
        );
    end

    mbox_flags u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mbox_on),
        .set_l  (wr_peer[1]),
        .clr_l  (rd_own[0]),
        .set_r  (wr_peer[0]),
        .clr_r  (rd_own[1]),
        .irq_l_n(irq_l_n),
        .irq_r_n(irq_r_n)
    );
endmodule

// File: tb/mbox_irq_ctrl_tb.sv
module mbox_irq_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mbox_on = 1'b1;
    logic l_ce_n = 1'b1, l_we_n = 1'b1, l_oe_n = 1'b1;
    logic r_ce_n = 1'b1, r_we_n = 1'b1, r_oe_n = 1'b1;
    logic [10:0] l_addr = '0, r_addr = '0;
    logic irq_l_n, irq_r_n;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    mbox_irq_ctrl u_dut (.*);

    task automatic check(string tag, logic act_l, logic act_r, logic exp_l, logic exp_r);
        n_chk++;
        if (act_l !== exp_l || act_r !== exp_r) begin
            n_fail++;
            $display("FAIL %s: irq_l_n/irq_r_n = %b%b expected %b%b", tag, act_l, act_r, exp_l, exp_r);
        end
    endtask

    task automatic drive(logic lc, logic lw, logic lo, logic [10:0] la,
                         logic rc, logic rw, logic ro, logic [10:0] ra);
        l_ce_n = lc; l_we_n = lw; l_oe_n = lo; l_addr = la;
        r_ce_n = rc; r_we_n = rw; r_oe_n = ro; r_addr = ra;
        @(negedge clk);
        l_ce_n = 1; l_we_n = 1; l_oe_n = 1; r_ce_n = 1; r_we_n = 1; r_oe_n = 1;
    endtask

    task automatic idle_cycle();
        drive(1, 1, 1, 11'h000, 1, 1, 1, 11'h000);
    endtask

    task automatic t_reset();
        check("R1 reset", irq_l_n, irq_r_n, 1, 1);
    endtask

    task automatic t_set_clear();
        drive(1, 1, 1, 0, 0, 0, 1, 11'h7FE);
        check("R2 right writes 7FE", irq_l_n, irq_r_n, 0, 1);
        drive(0, 0, 1, 11'h7FF, 1, 1, 1, 0);
        check("R3 left writes 7FF", irq_l_n, irq_r_n, 0, 0);
        drive(0, 1, 0, 11'h7FE, 1, 1, 1, 0);
        check("R4 left reads 7FE", irq_l_n, irq_r_n, 1, 0);
        drive(1, 1, 1, 0, 0, 1, 0, 11'h7FF);
        check("R5 right reads 7FF", irq_l_n, irq_r_n, 1, 1);
        drive(1, 1, 1, 0, 0, 0, 1, 11'h7FE);
        drive(0, 0, 0, 11'h7FE, 1, 1, 1, 0);
        check("R4 clear with write select low", irq_l_n, irq_r_n, 1, 1);
        drive(0, 0, 1, 11'h7FF, 1, 1, 1, 0);
        drive(1, 1, 1, 0, 0, 0, 0, 11'h7FF);
        check("R5 clear with write select low", irq_l_n, irq_r_n, 1, 1);
    endtask

    task automatic t_priority();
        drive(1, 1, 1, 0, 0, 0, 1, 11'h7FE);
        drive(0, 1, 0, 11'h7FE, 0, 0, 1, 11'h7FE);
        check("R6 set wins, flag already set", irq_l_n, irq_r_n, 0, 1);
        drive(0, 1, 0, 11'h7FE, 1, 1, 1, 0);
        drive(0, 0, 1, 11'h7FF, 0, 1, 0, 11'h7FF);
        check("R6 set wins, flag initially clear", irq_l_n, irq_r_n, 1, 0);
        drive(1, 1, 1, 0, 0, 1, 0, 11'h7FF);
        check("R6 cleanup", irq_l_n, irq_r_n, 1, 1);
    endtask

    task automatic t_own_write();
        drive(0, 0, 1, 11'h7FE, 0, 0, 1, 11'h7FF);
        check("R7 own-slot writes, flags clear", irq_l_n, irq_r_n, 1, 1);
        drive(1, 1, 1, 0, 0, 0, 1, 11'h7FE);
        drive(0, 0, 1, 11'h7FF, 1, 1, 1, 0);
        drive(0, 0, 1, 11'h7FE, 0, 0, 1, 11'h7FF);
        check("R7 own-slot writes, flags set", irq_l_n, irq_r_n, 0, 0);
    endtask

    task automatic t_hold();
        drive(0, 1, 0, 11'h7FF, 0, 1, 0, 11'h7FE);
        check("R8 peer slot reads", irq_l_n, irq_r_n, 0, 0);
        drive(1, 1, 0, 11'h7FE, 1, 1, 0, 11'h7FF);
        check("R8 enable high", irq_l_n, irq_r_n, 0, 0);
        drive(0, 0, 0, 11'h7FD, 0, 0, 0, 11'h3FE);
        check("R8 other addresses", irq_l_n, irq_r_n, 0, 0);
        repeat (3) idle_cycle();
        check("R8 idle hold", irq_l_n, irq_r_n, 0, 0);
    endtask

    task automatic t_mode_off();
        mbox_on = 0;
        idle_cycle();
        check("R9 mode off clears flags", irq_l_n, irq_r_n, 1, 1);
        drive(0, 0, 1, 11'h7FF, 0, 0, 1, 11'h7FE);
        check("R9 mode off, writes set nothing", irq_l_n, irq_r_n, 1, 1);
        mbox_on = 1;
        idle_cycle();
        check("R9 mode back on, still clear", irq_l_n, irq_r_n, 1, 1);
        drive(1, 1, 1, 0, 0, 0, 1, 11'h7FE);
        check("R2 works after mode on", irq_l_n, irq_r_n, 0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        idle_cycle();
        t_reset();
        t_set_clear();
        t_priority();
        t_own_write();
        t_hold();
        t_mode_off();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: timeout");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule